// File: doc/BRIEF.md
# LIN Auto-Baud Slave Receive/Transmit Engine

This block serves one LIN slave node on a single receive/transmit line pair. A detector watches the receive line for a long dominant break and then the 0x55 synchronisation byte. It times that byte's falling edges and derives the bit-time divisor in system clocks. After a sync is accepted, the receiver samples framed bytes with the new divisor and places them in a receive buffer. Software writes bytes to a transmit buffer, and the block serialises them at the current divisor. Protocol work such as identifier parity, checksums and scheduling stays in software.

Receiving stops when a stop bit is sampled as zero, when software asks it to stop, or when software writes a byte to transmit. It stays stopped until the next valid break/sync. A debug setting switches off the receiver and the sync detector. In that setting, and only in it, software may set the divisor by hand, so the block becomes a transmit-only UART. An optional timer flags a long recessive period on the receive line.

Registers are byte wide: 0 configuration, 1 data, 2 interrupt enable, 3 status, 4 divisor low byte, 5 divisor high byte.

Top module: `lin_sync_engine`

## Requirements
- R1: After reset the receiver is hunting for a sync but not running (status bit 3 = 0), the inactivity timer is off, the divisor reads DEFAULT_DIV, status bits 0..2 are 0, irq is 0 and txd is high.
- R2: A dominant period of at least 11*MAX_DIV clocks, followed by a 0x55 byte, loads the divisor with the time of its four two-bit falling-edge intervals divided by 8. It also sets status bit 0 (sync seen) and starts the receiver (status bit 3 = 1).
- R3: The sync is rejected if any two-bit interval differs from a quarter of the total by more than 5/32 of that quarter. In that case status bit 0 stays clear, the receiver stays stopped and the divisor is kept.
- R4: While running, the receiver samples each bit at mid-bit, LSB first, after a start bit. A byte with a high stop bit is placed in the buffer read at address 1 and sets status bit 1. That bit stays set, even after the data is read, until 1 is written to it at address 3 (status bits 0..2 are write-one-to-clear).
- R5: A stop bit sampled low stops the receiver, sets no status bit 1, and no further byte is accepted until a new sync.
- R6: A configuration write with bit 0 set (for example 0x1 or 0x5) stops the receiver until a new sync. Bit 0 is not stored.
- R7: A write to address 1 stops the receiver and transmits the byte on txd as a low start bit, 8 data bits LSB first and a high stop bit, each lasting divisor clocks. txd is high when idle.
- R8: Configuration bit 1 (for example 0x2 or 0x6) turns off the receiver, the sync detector and the inactivity timer.
- R9: Writes to addresses 4 and 5 change the divisor only while configuration bit 1 is set. Otherwise they are ignored.
- R10: With configuration bit 2 set and bit 1 clear, status bit 2 is set after the receive line has stayed high for TIMEOUT_CLKS clocks. Any edge on the line restarts the count.
- R11: irq is high exactly when some status bit 0..2 is set and the same bit is set in the enable register at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | LIN receive line (high = recessive) |
| txd | output | 1 | LIN transmit line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a sync field with one two-bit interval stretched by 25 percent. A detector without the deviation check would lock onto a wrong divisor and start accepting bytes. It sends a frame with a low stop bit and then a good byte. A receiver that ignores the stop error would take that byte in. It writes the divisor registers both outside and inside debug mode. A design that lets software override the auto-baud value would show the written value, and one that blocks the debug path would transmit at the old rate. It also holds the line idle with the timer disabled, directly and through the receiver-off setting, where a timer missing its gating would raise a timeout flag.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
   localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
   localparam logic [ADDR_W-1:0] A_IEN  = 3'd2;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
   localparam logic [ADDR_W-1:0] A_DIVL = 3'd4;
   localparam logic [ADDR_W-1:0] A_DIVH = 3'd5;

   // configuration bits
   localparam int CFG_STOP = 0;
   localparam int CFG_OFF  = 1;
   localparam int CFG_TMR  = 2;

   // status bits
   localparam int ST_SYNC = 0;
   localparam int ST_RDY  = 1;
   localparam int ST_TO   = 2;
   localparam int ST_RUN  = 3;
   localparam int N_FLAGS = 3;
endpackage

// File: rtl/lin_sync_detect.sv
module lin_sync_detect #(
   parameter int MAX_DIV = 16000,
   parameter int DIV_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             rx_s,
   input  logic             rx_fall,
   input  logic             rx_rise,
   output logic             sync_ok,
   output logic [DIV_W-1:0] div_out
);
   localparam int BREAK_CLKS = 11 * MAX_DIV;
   localparam int LOW_W      = $clog2(BREAK_CLKS + 1);
   localparam int IV_MAX     = 2 * MAX_DIV + MAX_DIV / 2;
   localparam int IV_W       = $clog2(IV_MAX + 1);
   localparam int TOT_W      = IV_W + 2;
   localparam int N_IV       = 4;

   typedef enum logic [1:0] {D_HUNT, D_DELIM, D_MEAS, D_CHECK} dstate_t;

   dstate_t          state;
   logic [LOW_W-1:0] low_cnt;
   logic [IV_W-1:0]  iv_cnt;
   logic [1:0]       iv_idx;
   logic [IV_W-1:0]  iv_q [N_IV];
   logic [TOT_W-1:0] total;
   logic [TOT_W-1:0] thresh;
   logic             all_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= D_HUNT;
         low_cnt <= '0;
         iv_cnt  <= '0;
         iv_idx  <= '0;
         for (int i = 0; i < N_IV; i++) iv_q[i] <= '0;
      end else if (!enable) begin
         state   <= D_HUNT;
         low_cnt <= '0;
      end else begin
         if (rx_s)                                low_cnt <= '0;
         else if (low_cnt != LOW_W'(BREAK_CLKS))  low_cnt <= low_cnt + 1'b1;

         if (rx_rise && low_cnt == LOW_W'(BREAK_CLKS)) begin
            state <= D_DELIM;
         end else begin
            case (state)
               D_DELIM: if (rx_fall) begin
                  state  <= D_MEAS;
                  iv_cnt <= IV_W'(1);
                  iv_idx <= '0;
               end
               D_MEAS: if (rx_fall) begin
                  iv_q[iv_idx] <= iv_cnt;
                  iv_cnt       <= IV_W'(1);
                  iv_idx       <= iv_idx + 1'b1;
                  if (iv_idx == 2'd3) state <= D_CHECK;
               end else if (iv_cnt == IV_W'(IV_MAX)) begin
                  state <= D_HUNT;
               end else begin
                  iv_cnt <= iv_cnt + 1'b1;
               end
               D_CHECK: state <= D_HUNT;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < N_IV; i++) total = total + TOT_W'(iv_q[i]);
      thresh = (total >> 3) + (total >> 5);
      all_ok = (total >> 3) != '0;
      for (int i = 0; i < N_IV; i++) begin
         logic [TOT_W-1:0] quad;
         logic [TOT_W-1:0] dev;
         quad = {iv_q[i], 2'b00};
         dev  = (quad > total) ? quad - total : total - quad;
         if (dev > thresh) all_ok = 1'b0;
      end
   end

   assign sync_ok = (state == D_CHECK) && all_ok;
   assign div_out = DIV_W'(total >> 3);
endmodule

// File: rtl/lin_rx_byte.sv
module lin_rx_byte #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rx_s,
   input  logic             rx_fall,
   input  logic [DIV_W-1:0] div,
   output logic             byte_valid,
   output logic [7:0]       byte_data,
   output logic             stop_err
);
   typedef enum logic [2:0] {R_IDLE, R_READY, R_START, R_DATA, R_STOP} rstate_t;

   rstate_t          state;
   logic [DIV_W-1:0] cnt;
   logic [2:0]       bitn;
   logic [7:0]       shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= R_IDLE;
         cnt        <= '0;
         bitn       <= '0;
         shreg      <= '0;
         byte_valid <= 1'b0;
         stop_err   <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         stop_err   <= 1'b0;
         if (!run) begin
            state <= R_IDLE;
         end else begin
            case (state)
               R_IDLE:  if (rx_s) state <= R_READY;
               R_READY: if (rx_fall) begin
                  cnt   <= div >> 1;
                  state <= R_START;
               end
               R_START: if (cnt == '0) begin
                  if (!rx_s) begin
                     cnt   <= div - 1'b1;
                     bitn  <= '0;
                     state <= R_DATA;
                  end else begin
                     state <= R_READY;
                  end
               end else cnt <= cnt - 1'b1;
               R_DATA: if (cnt == '0) begin
                  shreg <= {rx_s, shreg[7:1]};
                  cnt   <= div - 1'b1;
                  if (bitn == 3'd7) state <= R_STOP;
                  else              bitn  <= bitn + 1'b1;
               end else cnt <= cnt - 1'b1;
               R_STOP: if (cnt == '0) begin
                  if (rx_s) begin
                     byte_valid <= 1'b1;
                     state      <= R_READY;
                  end else begin
                     stop_err <= 1'b1;
                     state    <= R_IDLE;
                  end
               end else cnt <= cnt - 1'b1;
               default: state <= R_IDLE;
            endcase
         end
      end
   end

   assign byte_data = shreg;
endmodule

// File: rtl/lin_tx_byte.sv
module lin_tx_byte #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [7:0]       data,
   input  logic [DIV_W-1:0] div,
   output logic             txd,
   output logic             busy
);
   localparam int FRAME_BITS = 10;

   logic [FRAME_BITS-1:0] sh;
   logic [3:0]            bits_left;
   logic [DIV_W-1:0]      cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '1;
         bits_left <= '0;
         cnt       <= '0;
         busy      <= 1'b0;
      end else if (!busy) begin
         if (load) begin
            sh        <= {1'b1, data, 1'b0};
            bits_left <= 4'(FRAME_BITS);
            cnt       <= div - 1'b1;
            busy      <= 1'b1;
         end
      end else if (cnt == '0) begin
         cnt <= div - 1'b1;
         if (bits_left == 4'd1) begin
            busy <= 1'b0;
            sh   <= '1;
         end else begin
            bits_left <= bits_left - 1'b1;
            sh        <= {1'b1, sh[FRAME_BITS-1:1]};
         end
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign txd = !busy || sh[0];
endmodule

// File: rtl/lin_idle_timer.sv
module lin_idle_timer #(
   parameter int TIMEOUT_CLKS = 64000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic rx_s,
   input  logic rx_edge,
   output logic fire
);
   localparam int TO_W = $clog2(TIMEOUT_CLKS + 1);

   logic [TO_W-1:0] cnt;
   logic            active;

   assign active = enable && rx_s && !rx_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (!active)                      cnt <= '0;
      else if (cnt != TO_W'(TIMEOUT_CLKS))   cnt <= cnt + 1'b1;
   end

   assign fire = active && (cnt == TO_W'(TIMEOUT_CLKS - 1));
endmodule

// File: rtl/lin_sync_engine.sv
module lin_sync_engine
   import lin_sync_pkg::*;
#(
   parameter int DIV_W        = 16,
   parameter int MAX_DIV      = 16000,
   parameter int DEFAULT_DIV  = 139,
   parameter int TIMEOUT_CLKS = 64000000,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_TIMER    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   output logic              txd,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_W > 16 || DIV_W < 2) begin : g_bad_divw
      $error("DIV_W must lie in 2..16");
   end
   if (MAX_DIV < 2 || $clog2(MAX_DIV + 1) > DIV_W) begin : g_bad_maxdiv
      $error("MAX_DIV must fit in DIV_W bits");
   end
   if (DEFAULT_DIV < 1 || DEFAULT_DIV > MAX_DIV) begin : g_bad_default
      $error("DEFAULT_DIV must lie in 1..MAX_DIV");
   end

   logic [SYNC_STAGES-1:0] rx_pipe;
   logic                   rx_s, rx_prev, rx_fall, rx_rise;
   logic                   rx_off_q, timer_en_q, rx_run_q;
   logic [N_FLAGS-1:0]     stat_q, ien_q;
   logic [DIV_W-1:0]       div_q, det_div;
   logic [15:0]            div_ext;
   logic [7:0]             rx_buf;
   logic                   sync_ok, byte_valid, stop_err, to_fire, tx_busy;
   logic [7:0]             byte_data;
   logic                   wr_cfg, wr_data, wr_stat, stop_req;

   // input synchroniser and edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_pipe <= '1;
         rx_prev <= 1'b1;
      end else begin
         rx_pipe <= {rx_pipe[SYNC_STAGES-2:0], rxd};
         rx_prev <= rx_s;
      end
   end
   assign rx_s    = rx_pipe[SYNC_STAGES-1];
   assign rx_fall = rx_prev && !rx_s;
   assign rx_rise = !rx_prev && rx_s;

   assign wr_cfg   = reg_we && reg_addr == A_CFG;
   assign wr_data  = reg_we && reg_addr == A_DATA;
   assign wr_stat  = reg_we && reg_addr == A_STAT;
   assign stop_req = wr_cfg && reg_wdata[CFG_STOP];
   assign div_ext  = 16'(div_q);

   lin_sync_detect #(.MAX_DIV(MAX_DIV), .DIV_W(DIV_W)) i_detect (
      .clk(clk), .rst_n(rst_n), .enable(!rx_off_q), .rx_s(rx_s),
      .rx_fall(rx_fall), .rx_rise(rx_rise), .sync_ok(sync_ok), .div_out(det_div)
   );

   lin_rx_byte #(.DIV_W(DIV_W)) i_rx (
      .clk(clk), .rst_n(rst_n), .run(rx_run_q), .rx_s(rx_s), .rx_fall(rx_fall),
      .div(div_q), .byte_valid(byte_valid), .byte_data(byte_data), .stop_err(stop_err)
   );

   lin_tx_byte #(.DIV_W(DIV_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .load(wr_data), .data(reg_wdata), .div(div_q),
      .txd(txd), .busy(tx_busy)
   );

   if (HAS_TIMER) begin : g_timer
      lin_idle_timer #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) i_timer (
         .clk(clk), .rst_n(rst_n), .enable(timer_en_q && !rx_off_q), .rx_s(rx_s),
         .rx_edge(rx_fall || rx_rise), .fire(to_fire)
      );
   end else begin : g_no_timer
      assign to_fire = 1'b0;
   end

   // configuration, run state, divisor, buffers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_off_q   <= 1'b0;
         timer_en_q <= 1'b0;
         rx_run_q   <= 1'b0;
         ien_q      <= '0;
         div_q      <= DIV_W'(DEFAULT_DIV);
         rx_buf     <= '0;
      end else begin
         if (wr_cfg) begin
            rx_off_q   <= reg_wdata[CFG_OFF];
            timer_en_q <= reg_wdata[CFG_TMR];
         end
         if (reg_we && reg_addr == A_IEN) ien_q <= reg_wdata[N_FLAGS-1:0];

         if (rx_off_q || stop_req || wr_data || stop_err) rx_run_q <= 1'b0;
         else if (sync_ok)                                 rx_run_q <= 1'b1;

         if (sync_ok && !rx_off_q)
            div_q <= det_div;
         else if (rx_off_q && reg_we && reg_addr == A_DIVL)
            div_q <= DIV_W'({div_ext[15:8], reg_wdata});
         else if (rx_off_q && reg_we && reg_addr == A_DIVH)
            div_q <= DIV_W'({reg_wdata, div_ext[7:0]});

         if (byte_valid) rx_buf <= byte_data;
      end
   end

   // status flags: set wins over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         logic [N_FLAGS-1:0] set_v;
         set_v = '0;
         set_v[ST_SYNC] = sync_ok;
         set_v[ST_RDY]  = byte_valid;
         set_v[ST_TO]   = to_fire;
         stat_q <= (stat_q & ~(wr_stat ? reg_wdata[N_FLAGS-1:0] : '0)) | set_v;
      end
   end

   always_comb begin
      case (reg_addr)
         A_CFG:   reg_rdata = {5'b0, timer_en_q, rx_off_q, 1'b0};
         A_DATA:  reg_rdata = rx_buf;
         A_IEN:   reg_rdata = {5'b0, ien_q};
         A_STAT:  reg_rdata = {4'b0, rx_run_q, stat_q};
         A_DIVL:  reg_rdata = div_ext[7:0];
         A_DIVH:  reg_rdata = div_ext[15:8];
         default: reg_rdata = 8'h00;
      endcase
   end

   assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/lin_sync_engine_chk.sv
module lin_sync_engine_chk #(
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [2:0]       reg_addr,
   input logic [7:0]       reg_wdata,
   input logic             rx_run,
   input logic             rx_off,
   input logic             timer_en,
   input logic             sync_ok,
   input logic             stop_err,
   input logic [DIV_W-1:0] div,
   input logic             stat_to,
   input logic             tx_busy,
   input logic             txd
);
   // R2
   run_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_run) |-> $past(sync_ok));

   // R5
   stop_err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_err |=> !rx_run);

   // R6
   stop_cmd_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd0 && reg_wdata[0]) |=> !rx_run);

   // R7
   tx_write_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd1) |=> !rx_run);

   // R7
   txd_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   // R8
   off_keeps_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_off && $past(rx_off)) |-> !rx_run);

   // R9
   div_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (reg_addr == 3'd4 || reg_addr == 3'd5) && !rx_off && !sync_ok)
      |=> $stable(div));

   // R10
   timeout_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_to) |-> $past(timer_en && !rx_off));
endmodule

bind lin_sync_engine lin_sync_engine_chk #(.DIV_W(DIV_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .rx_run(rx_run_q), .rx_off(rx_off_q),
   .timer_en(timer_en_q), .sync_ok(sync_ok), .stop_err(stop_err), .div(div_q),
   .stat_to(stat_q[2]), .tx_busy(tx_busy), .txd(txd)
);

// File: tb/test_lin_sync_engine.sv
module test_lin_sync_engine;
   localparam int MAX_DIV = 64;
   localparam int DEF_DIV = 24;
   localparam int TO_CLKS = 3000;
   localparam int BIT     = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       txd;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { logic [7:0] data; int div; } tx_item_t;
   tx_item_t tx_q[$];

   always #5 clk = ~clk;

   lin_sync_engine #(.DIV_W(16), .MAX_DIV(MAX_DIV), .DEFAULT_DIV(DEF_DIV),
                     .TIMEOUT_CLKS(TO_CLKS), .SYNC_STAGES(2), .HAS_TIMER(1'b1)) i_lin_sync_engine (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic expect_reg(input logic [2:0] a, input logic [7:0] mask,
                             input logic [7:0] exp, input string req);
      logic [7:0] v;
      rd(a, v);
      chk((v & mask) == exp, req, int'(v & mask), int'(exp));
   endtask

   task automatic line(input bit v, input int clocks);
      rxd = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_break();
      line(1'b0, 20 * BIT);
      line(1'b1, BIT);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit stop_v);
      line(1'b0, BIT);
      for (int i = 0; i < 8; i++) line(b[i], BIT);
      line(stop_v, BIT);
      line(1'b1, 2 * BIT);
   endtask

   task automatic send_sync(input int stretch);
      logic [7:0] s;
      s = 8'h55;
      line(1'b0, BIT);
      for (int i = 0; i < 8; i++) line(s[i], BIT + ((i == 2) ? stretch : 0));
      line(1'b1, 3 * BIT);
   endtask

   task automatic transmit(input logic [7:0] d, input int div);
      tx_item_t it;
      it.data = d; it.div = div;
      tx_q.push_back(it);
      wr(3'd1, d);
   endtask

   // TX monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd == 1'b0) begin
            tx_item_t it;
            logic [7:0] got;
            bit frame_ok;
            if (tx_q.size() == 0) begin
               chk(1'b0, "R7 unexpected tx frame", 0, 1);
               it.data = 8'h00; it.div = BIT;
            end else begin
               it = tx_q.pop_front();
            end
            frame_ok = 1'b1;
            repeat (it.div / 2) @(negedge clk);
            if (txd !== 1'b0) frame_ok = 1'b0;
            for (int i = 0; i < 8; i++) begin
               repeat (it.div) @(negedge clk);
               got[i] = txd;
            end
            repeat (it.div) @(negedge clk);
            if (txd !== 1'b1) frame_ok = 1'b0;
            chk(frame_ok && got == it.data, "R7 tx frame", int'(got), int'(it.data));
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      expect_reg(3'd3, 8'h0F, 8'h00, "R1 status after reset");
      expect_reg(3'd0, 8'hFF, 8'h00, "R1 config after reset");
      expect_reg(3'd4, 8'hFF, 8'(DEF_DIV), "R1 divisor after reset");
      chk(txd == 1'b1 && irq == 1'b0, "R1 txd/irq after reset", {txd, irq}, 2'b10);
      repeat (TO_CLKS + 200) @(negedge clk);
      expect_reg(3'd3, 8'h04, 8'h00, "R1 timer off after reset");

      // R9 divisor write ignored outside debug mode
      wr(3'd4, 8'h11);
      expect_reg(3'd4, 8'hFF, 8'(DEF_DIV), "R9 divisor write ignored");

      // R2 break + sync
      send_break();
      send_sync(0);
      expect_reg(3'd3, 8'h0F, 8'h09, "R2 sync flag and running");
      expect_reg(3'd4, 8'hFF, 8'(BIT), "R2 derived divisor");
      wr(3'd5, 8'h01);
      expect_reg(3'd5, 8'hFF, 8'h00, "R9 high divisor write ignored");

      // R11 interrupt gating
      chk(irq == 1'b0, "R11 irq masked", irq, 0);
      wr(3'd2, 8'h01);
      chk(irq == 1'b1, "R11 irq enabled", irq, 1);
      wr(3'd3, 8'h07);
      chk(irq == 1'b0, "R11 irq after clear", irq, 0);
      wr(3'd2, 8'h00);

      // R4 byte reception
      send_frame(8'hA5, 1'b1);
      expect_reg(3'd1, 8'hFF, 8'hA5, "R4 rx data A5");
      expect_reg(3'd3, 8'h02, 8'h02, "R4 rx ready sticky after read");
      wr(3'd3, 8'h02);
      expect_reg(3'd3, 8'h02, 8'h00, "R4 rx ready cleared");
      send_frame(8'h3C, 1'b1);
      expect_reg(3'd1, 8'hFF, 8'h3C, "R4 rx data 3C");
      wr(3'd3, 8'h07);

      // R5 zero stop bit
      send_frame(8'h00, 1'b0);
      expect_reg(3'd3, 8'h0A, 8'h00, "R5 stopped after bad stop");
      send_frame(8'h96, 1'b1);
      expect_reg(3'd3, 8'h02, 8'h00, "R5 byte ignored after bad stop");

      // R6 stop command
      send_break();
      send_sync(0);
      expect_reg(3'd3, 8'h08, 8'h08, "R6 running after resync");
      wr(3'd0, 8'h05);
      expect_reg(3'd3, 8'h08, 8'h00, "R6 stopped by command");
      expect_reg(3'd0, 8'h01, 8'h00, "R6 stop bit not stored");
      send_frame(8'h81, 1'b1);
      expect_reg(3'd3, 8'h02, 8'h00, "R6 byte ignored after stop");
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h07);

      // R7 tx write stops receiver
      send_break();
      send_sync(0);
      expect_reg(3'd3, 8'h08, 8'h08, "R7 running before tx");
      transmit(8'hC3, BIT);
      expect_reg(3'd3, 8'h08, 8'h00, "R7 stopped by tx write");
      repeat (12 * BIT) @(negedge clk);
      send_frame(8'h42, 1'b1);
      expect_reg(3'd3, 8'h02, 8'h00, "R7 byte ignored after tx");
      wr(3'd3, 8'h07);

      // R3 distorted sync
      send_break();
      send_sync(20);
      expect_reg(3'd3, 8'h09, 8'h00, "R3 distorted sync rejected");
      expect_reg(3'd4, 8'hFF, 8'(BIT), "R3 divisor kept");

      // R8 debug mode, R9 manual divisor
      wr(3'd0, 8'h02);
      send_break();
      send_sync(0);
      expect_reg(3'd3, 8'h09, 8'h00, "R8 no sync while off");
      wr(3'd4, 8'h20);
      wr(3'd5, 8'h00);
      expect_reg(3'd4, 8'hFF, 8'h20, "R9 divisor written in debug");
      transmit(8'h5A, 32);
      repeat (12 * 32) @(negedge clk);

      // R8 / R10 inactivity timer
      wr(3'd3, 8'h07);
      wr(3'd0, 8'h06);
      repeat (TO_CLKS + 200) @(negedge clk);
      expect_reg(3'd3, 8'h04, 8'h00, "R8 timer off while rx off");
      wr(3'd0, 8'h04);
      repeat (TO_CLKS / 2) @(negedge clk);
      line(1'b0, 4);
      line(1'b1, 1);
      repeat (TO_CLKS - 100) @(negedge clk);
      expect_reg(3'd3, 8'h04, 8'h00, "R10 edge restarts timer");
      repeat (300) @(negedge clk);
      expect_reg(3'd3, 8'h04, 8'h04, "R10 timeout flag");
      wr(3'd2, 8'h04);
      chk(irq == 1'b1, "R11 irq on timeout", irq, 1);

      chk(tx_q.size() == 0, "R7 all tx frames seen", tx_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule